// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block runs the refill of one 32-byte cache line after a miss. It takes the line from the next memory level as four 64-bit beats. The first beat is always the double word that holds the missed address. Later beats go up in double-word order and wrap past the end of the line. Every beat goes to the cache data array through a write port. In the same cycle, the first beat is also handed to the requester. A mode bit, taken when the miss is accepted, makes every beat go to the requester, as an instruction fetch path would need. A miss of either kind (a read, or a write that fetches the line before changing it) starts the same fill.

The block holds the tag and valid state of a set-associative directory. It answers lookups every cycle, including while a fill is running, so hits to other lines never wait for the fill. A lookup that lands on the line being filled reports a stall while the wanted double word is still missing, and reports a hit once that double word has been written. The line becomes valid in the directory only when the fourth beat has been written. Only one fill runs at a time. A new miss is held off until the current fill completes.

Address layout, as used by every port that carries one: bits [2:0] give the byte in the double word, bits [4:3] the double word in the line, bits [8:5] the set (16 sets), and bits [31:9] the tag.

Top module: `cwf_line_fill`

## Requirements
- R1: A miss is accepted on a rising edge where miss_valid and miss_ready are both high. miss_ready is low from the cycle after acceptance until the fill completes. A miss presented during that time is held and is accepted in the cycle fill_done is high.
- R2: During a fill, each cycle with mem_valid high writes one beat: arr_we is 1, arr_way is the requested way, arr_index is address bits [8:5], and arr_wdata equals mem_data in that same cycle. The fill ends after four such beats.
- R3: The first beat is written at double word miss_addr[4:3]. Each following beat is at the previous double word plus one, modulo 4 (for example 2, 3, 0, 1).
- R4: The first beat raises fwd_valid in its own write cycle, with fwd_data equal to mem_data and fwd_dword equal to miss_addr[4:3].
- R5: When fwd_all_beats is 1 at acceptance, all four beats are forwarded as they are written. When it is 0, only the first beat is forwarded.
- R6: mem_valid while no fill is running is ignored. arr_we and fwd_valid stay 0, and the next fill still starts at its critical double word.
- R7: fill_done is high for exactly one cycle, the cycle after the fourth beat. miss_ready is 1 in that cycle.
- R8: While a fill is running, a lookup of another valid line reports lk_hit=1 with its way and lk_stall=0, including in a cycle where a beat is being written.
- R9: A lookup of the line being filled reports lk_stall=1 and lk_hit=0 up to and including the cycle in which the wanted double word is written. From the next cycle it reports lk_hit=1 with the fill way.
- R10: The line in the target way is invalidated when the miss is accepted, so lookups of it miss. The new line is valid from the fill_done cycle on: lk_hit=1 with lk_stall=0.
- R11: After reset, miss_ready=1, arr_we=0, fwd_valid=0, fill_done=0, and every lookup misses without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Missed byte address |
| miss_way | input | 1 | Way to refill |
| fwd_all_beats | input | 1 | Forward every beat of this fill, not only the first |
| miss_ready | output | 1 | No fill running, miss can be accepted |
| mem_valid | input | 1 | Beat present from memory |
| mem_data | input | 64 | Beat data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hits, data readable |
| lk_way | output | 1 | Way of the hit |
| lk_stall | output | 1 | Lookup targets the filling line before its double word arrived |
| arr_we | output | 1 | Data array write enable |
| arr_way | output | 1 | Data array way |
| arr_index | output | 4 | Data array set |
| arr_dword | output | 2 | Double word within the line |
| arr_wdata | output | 64 | Data array write data |
| fwd_valid | output | 1 | Forwarded beat to requester valid |
| fwd_dword | output | 2 | Double word being forwarded |
| fwd_data | output | 64 | Forwarded data |
| fill_done | output | 1 | One-cycle pulse when the line is complete |

## Verification
Two pairs of functions can happen in the same cycle. The first pair is a beat write with its forward, together with a lookup. The bench holds lookups on the port while a beat lands. It checks that a hit to a different line comes back with its own way. It also checks that a lookup of the double word landing in that very cycle still stalls, and turns into a hit one cycle later. The second pair is fill completion and a new miss. The bench keeps a second miss raised through a whole fill. It checks that the running beats stay untouched and that the held miss is accepted in the fill_done cycle, with its beats starting at its own critical double word.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int LINE_BYTES = 32;
  localparam int BEAT_BYTES = 8;
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_W     = BEAT_BYTES * 8;
  localparam int DW_W       = $clog2(BEATS);
  localparam int BYTE_W     = $clog2(BEAT_BYTES);
  localparam int OFF_W      = $clog2(LINE_BYTES);

  typedef logic [DW_W-1:0]  dw_t;
  typedef logic [BEATS-1:0] beat_mask_t;

  // Double word carried by beat number k when the fill began at crit.
  function automatic dw_t wrap_dw(input dw_t crit, input dw_t k);
    return crit + k;
  endfunction
endpackage

// File: rtl/cwf_tag_store.sv
module cwf_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int TAG_W = 23,
  parameter int IDX_W = 4,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [WAY_W-1:0] inv_way,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAY_W-1:0] set_way,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  match;

  always_comb begin
    vld_d = vld_q;
    if (inv_en) vld_d[inv_idx][inv_way] = 1'b0;
    if (set_en) vld_d[set_idx][set_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (inv_en) tag_q[inv_idx][inv_way] <= inv_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) lk_way = WAY_W'(w);
    end
  end
  assign lk_hit = |match;

  // R8: a line lives in at most one way of its set
  p_single_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq
  import cwf_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 23,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  dw_t              start_dw,
  input  logic             start_all,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [WAY_W-1:0] start_way,
  input  logic             beat_in,
  output logic             busy,
  output logic             wr,
  output logic             last_wr,
  output logic             first,
  output logic             fwd_all,
  output dw_t              cur_dw,
  output beat_mask_t       got,
  output logic             done,
  output logic [IDX_W-1:0] fill_idx,
  output logic [TAG_W-1:0] fill_tag,
  output logic [WAY_W-1:0] fill_way
);
  logic             busy_q, busy_d, done_q, done_d, all_q;
  dw_t              cnt_q, cnt_d, crit_q;
  beat_mask_t       got_q, got_d;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic [WAY_W-1:0] way_q;
  logic             cnt_en;

  assign wr      = busy_q && beat_in;
  assign last_wr = wr && (cnt_q == dw_t'(BEATS - 1));
  assign cur_dw  = wrap_dw(crit_q, cnt_q);
  assign cnt_en  = start || wr;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    got_d  = got_q;
    done_d = last_wr;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      got_d  = '0;
    end else if (wr) begin
      cnt_d  = cnt_q + dw_t'(1);
      got_d  = got_q | (beat_mask_t'(1) << cur_dw);
      if (last_wr) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      got_q  <= '0;
      crit_q <= '0;
      all_q  <= 1'b0;
      idx_q  <= '0;
      tag_q  <= '0;
      way_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        got_q <= got_d;
      end
      if (start) begin
        crit_q <= start_dw;
        all_q  <= start_all;
        idx_q  <= start_idx;
        tag_q  <= start_tag;
        way_q  <= start_way;
      end
    end
  end

  assign busy     = busy_q;
  assign first    = (cnt_q == '0);
  assign fwd_all  = all_q;
  assign got      = got_q;
  assign done     = done_q;
  assign fill_idx = idx_q;
  assign fill_tag = tag_q;
  assign fill_way = way_q;

  // R3: the beat after acceptance targets the critical double word
  p_crit_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cur_dw == $past(start_dw)));
  // R7: completion only follows a running fill
  p_done_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R10: every double word arrived before completion
  p_all_beats_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (got_q == '1));
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [WAY_W-1:0]  miss_way,
  input  logic              fwd_all_beats,
  output logic              miss_ready,
  input  logic              mem_valid,
  input  logic [BEAT_W-1:0] mem_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic              lk_stall,
  output logic              arr_we,
  output logic [WAY_W-1:0]  arr_way,
  output logic [IDX_W-1:0]  arr_index,
  output logic [DW_W-1:0]   arr_dword,
  output logic [BEAT_W-1:0] arr_wdata,
  output logic              fwd_valid,
  output logic [DW_W-1:0]   fwd_dword,
  output logic [BEAT_W-1:0] fwd_data,
  output logic              fill_done
);
  logic             busy, wr, last_wr, first, fwd_all, start, done;
  dw_t              cur_dw;
  beat_mask_t       got;
  logic [IDX_W-1:0] fill_idx, lk_idx, m_idx;
  logic [TAG_W-1:0] fill_tag, lk_tag, m_tag;
  logic [WAY_W-1:0] fill_way, ts_way;
  dw_t              lk_dw, m_dw;
  logic             ts_hit, on_fill, dw_here;
  logic             unused_byte_bits;

  assign m_dw   = miss_addr[BYTE_W +: DW_W];
  assign m_idx  = miss_addr[OFF_W +: IDX_W];
  assign m_tag  = miss_addr[ADDR_W-1 -: TAG_W];
  assign lk_dw  = lk_addr[BYTE_W +: DW_W];
  assign lk_idx = lk_addr[OFF_W +: IDX_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign unused_byte_bits = ^{miss_addr[BYTE_W-1:0], lk_addr[BYTE_W-1:0]};

  assign start = miss_valid && !busy;

  cwf_fill_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dw(m_dw),
    .start_all(fwd_all_beats), .start_idx(m_idx), .start_tag(m_tag),
    .start_way(miss_way), .beat_in(mem_valid), .busy(busy), .wr(wr),
    .last_wr(last_wr), .first(first), .fwd_all(fwd_all), .cur_dw(cur_dw),
    .got(got), .done(done), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .fill_way(fill_way)
  );

  cwf_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W),
                  .WAY_W(WAY_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .inv_en(start), .inv_idx(m_idx),
    .inv_way(miss_way), .inv_tag(m_tag), .set_en(last_wr),
    .set_idx(fill_idx), .set_way(fill_way), .lk_idx(lk_idx),
    .lk_tag(lk_tag), .lk_hit(ts_hit), .lk_way(ts_way)
  );

  // Lookup path: the filling line answers from its arrival mask.
  assign on_fill  = lk_valid && busy && (lk_idx == fill_idx) && (lk_tag == fill_tag);
  assign dw_here  = got[lk_dw];
  assign lk_stall = on_fill && !dw_here;
  assign lk_hit   = lk_valid && (on_fill ? dw_here : ts_hit);
  assign lk_way   = on_fill ? fill_way : ts_way;

  // Array write and forward path, both driven by the same beat.
  assign arr_we     = wr;
  assign arr_way    = fill_way;
  assign arr_index  = fill_idx;
  assign arr_dword  = cur_dw;
  assign arr_wdata  = mem_data;
  assign fwd_valid  = wr && (first || fwd_all);
  assign fwd_dword  = cur_dw;
  assign fwd_data   = mem_data;
  assign fill_done  = done;
  assign miss_ready = !busy;

  // R4: a forward always coincides with the array write of the same data
  p_fwd_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (arr_we && fwd_data == arr_wdata && fwd_dword == arr_dword));
  // R9: a stalled lookup never reports a hit
  p_stall_not_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stall |-> !lk_hit);
  // R1: accepting a miss closes the request port on the next cycle
  p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);
  // R7: the completion cycle reopens the request port
  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> miss_ready);
endmodule

// File: tb/sim_cwf_line_fill.sv
`timescale 1ns/1ps
module sim_cwf_line_fill;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid, fwd_all_beats, mem_valid, lk_valid;
  logic [31:0] miss_addr, lk_addr;
  logic        miss_way;
  logic [63:0] mem_data;
  logic        miss_ready, lk_hit, lk_way, lk_stall, arr_we, arr_way;
  logic        fwd_valid, fill_done;
  logic [3:0]  arr_index;
  logic [1:0]  arr_dword, fwd_dword;
  logic [63:0] arr_wdata, fwd_data;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cwf_line_fill u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_way(miss_way), .fwd_all_beats(fwd_all_beats), .miss_ready(miss_ready),
    .mem_valid(mem_valid), .mem_data(mem_data), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way), .lk_stall(lk_stall),
    .arr_we(arr_we), .arr_way(arr_way), .arr_index(arr_index),
    .arr_dword(arr_dword), .arr_wdata(arr_wdata), .fwd_valid(fwd_valid),
    .fwd_dword(fwd_dword), .fwd_data(fwd_data), .fill_done(fill_done)
  );

  // {address, way, forward-all}
  localparam logic [33:0] VEC [6] = '{
    {32'h0000_2340, 1'b0, 1'b0},
    {32'h0000_2568, 1'b1, 1'b1},
    {32'h0000_2790, 1'b1, 1'b0},
    {32'h0000_29B8, 1'b0, 1'b1},
    {32'h0000_2BD5, 1'b1, 1'b1},
    {32'h0000_2DE8, 1'b0, 1'b0}
  };

  function automatic logic [31:0] mk(input int tag, input int idx, input int dw);
    return (32'(tag) << 9) | (32'(idx) << 5) | (32'(dw) << 3);
  endfunction

  function automatic logic [63:0] bdat(input logic [31:0] a, input int k);
    return {a, 32'hC0DE_0000 | 32'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic accept(input logic [31:0] a, input logic w, input bit all);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; miss_way = w; fwd_all_beats = all;
    #1 chk(miss_ready == 1'b1, "R1", "ready before accept", 64'(miss_ready), 64'd1);
    @(posedge clk); #1;
    miss_valid = 1'b0;
    @(negedge clk);
    chk(miss_ready == 1'b0, "R1", "ready while filling", 64'(miss_ready), 64'd0);
  endtask

  task automatic beat(input logic [31:0] a, input logic w, input bit all, input int k,
                      input bit do_lk, input logic [31:0] la, input bit eh,
                      input bit es, input logic ew, input string lr);
    logic [1:0] edw;
    bit efw;
    edw = a[4:3] + 2'(k);
    efw = (k == 0) || all;
    @(negedge clk);
    mem_valid = 1'b1; mem_data = bdat(a, k); lk_valid = do_lk; lk_addr = la;
    #1;
    chk(arr_we == 1'b1, "R2", "arr_we", 64'(arr_we), 64'd1);
    chk(arr_way == w, "R2", "arr_way", 64'(arr_way), 64'(w));
    chk(arr_index == a[8:5], "R2", "arr_index", 64'(arr_index), 64'(a[8:5]));
    chk(arr_wdata == bdat(a, k), "R2", "arr_wdata", arr_wdata, bdat(a, k));
    chk(arr_dword == edw, "R3", "arr_dword", 64'(arr_dword), 64'(edw));
    chk(fwd_valid == efw, (k == 0) ? "R4" : "R5", "fwd_valid", 64'(fwd_valid), 64'(efw));
    if (efw) begin
      chk(fwd_data == bdat(a, k), "R4", "fwd_data", fwd_data, bdat(a, k));
      chk(fwd_dword == edw, "R4", "fwd_dword", 64'(fwd_dword), 64'(edw));
    end
    chk(fill_done == 1'b0, "R7", "done during beats", 64'(fill_done), 64'd0);
    if (do_lk) begin
      chk(lk_hit == eh, lr, "lk_hit with beat", 64'(lk_hit), 64'(eh));
      chk(lk_stall == es, lr, "lk_stall with beat", 64'(lk_stall), 64'(es));
      if (eh) chk(lk_way == ew, lr, "lk_way with beat", 64'(lk_way), 64'(ew));
    end
    @(posedge clk); #1;
    mem_valid = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] la, input bit eh, input bit es,
                        input logic ew, input string lr);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = la;
    #1;
    chk(lk_hit == eh, lr, "lk_hit", 64'(lk_hit), 64'(eh));
    chk(lk_stall == es, lr, "lk_stall", 64'(lk_stall), 64'(es));
    if (eh) chk(lk_way == ew, lr, "lk_way", 64'(lk_way), 64'(ew));
    lk_valid = 1'b0;
  endtask

  task automatic post(input logic [31:0] a, input logic w);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    #1;
    chk(fill_done == 1'b1, "R7", "done pulse", 64'(fill_done), 64'd1);
    chk(miss_ready == 1'b1, "R7", "ready at done", 64'(miss_ready), 64'd1);
    chk(lk_hit == 1'b1 && lk_stall == 1'b0, "R10", "line valid at done",
        64'({lk_hit, lk_stall}), 64'b10);
    chk(lk_way == w, "R10", "way at done", 64'(lk_way), 64'(w));
    lk_valid = 1'b0;
    @(negedge clk);
    #1 chk(fill_done == 1'b0, "R7", "done width", 64'(fill_done), 64'd0);
  endtask

  task automatic full_fill(input logic [31:0] a, input logic w, input bit all);
    accept(a, w, all);
    for (int k = 0; k < 4; k++) beat(a, w, all, k, 1'b0, '0, 1'b0, 1'b0, 1'b0, "");
    post(a, w);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c, d, e, f;
    rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0; miss_way = 1'b0;
    fwd_all_beats = 1'b0; mem_valid = 1'b0; mem_data = '0;
    lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: reset state
    @(negedge clk); #1;
    chk(miss_ready == 1'b1, "R11", "miss_ready", 64'(miss_ready), 64'd1);
    chk(arr_we == 1'b0, "R11", "arr_we", 64'(arr_we), 64'd0);
    chk(fwd_valid == 1'b0, "R11", "fwd_valid", 64'(fwd_valid), 64'd0);
    chk(fill_done == 1'b0, "R11", "fill_done", 64'(fill_done), 64'd0);
    lookup(32'h0000_2340, 1'b0, 1'b0, 1'b0, "R11");

    // R6: beats with no fill running
    @(negedge clk);
    mem_valid = 1'b1; mem_data = 64'hDEAD_BEEF_0000_0001;
    #1 chk(arr_we == 1'b0, "R6", "arr_we idle", 64'(arr_we), 64'd0);
    chk(fwd_valid == 1'b0, "R6", "fwd_valid idle", 64'(fwd_valid), 64'd0);
    @(negedge clk);
    #1 chk(arr_we == 1'b0 && fwd_valid == 1'b0, "R6", "idle second cycle",
           64'({arr_we, fwd_valid}), 64'd0);
    mem_valid = 1'b0;
    full_fill(mk(3, 2, 2), 1'b1, 1'b0); // R6 first beat still critical

    // Table walk: R2 R3 R4 R5 R7 R10
    for (int i = 0; i < 6; i++) full_fill(VEC[i][33:2], VEC[i][1], VEC[i][0]);

    // R8 R9: lookups alongside beats
    a = mk(40, 3, 1);
    b = mk(41, 3, 2);
    full_fill(a, 1'b0, 1'b0);
    accept(b, 1'b1, 1'b0);
    lookup(mk(41, 3, 0), 1'b0, 1'b1, 1'b0, "R9");
    beat(b, 1'b1, 1'b0, 0, 1'b1, a, 1'b1, 1'b0, 1'b0, "R8");
    beat(b, 1'b1, 1'b0, 1, 1'b1, mk(41, 3, 2), 1'b1, 1'b0, 1'b1, "R9");
    beat(b, 1'b1, 1'b0, 2, 1'b1, mk(41, 3, 0), 1'b0, 1'b1, 1'b0, "R9");
    beat(b, 1'b1, 1'b0, 3, 1'b1, mk(41, 3, 0), 1'b1, 1'b0, 1'b1, "R9");
    post(b, 1'b1);
    lookup(a, 1'b1, 1'b0, 1'b0, "R8");

    // R1: a miss held through a running fill
    c = mk(50, 7, 0);
    d = mk(51, 9, 3);
    accept(c, 1'b1, 1'b1);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = d; miss_way = 1'b0; fwd_all_beats = 1'b0;
    #1 chk(miss_ready == 1'b0, "R1", "held miss not taken", 64'(miss_ready), 64'd0);
    for (int k = 0; k < 4; k++) beat(c, 1'b1, 1'b1, k, 1'b0, '0, 1'b0, 1'b0, 1'b0, "");
    post(c, 1'b1);
    miss_valid = 1'b0;
    #1 chk(miss_ready == 1'b0, "R1", "held miss taken at done", 64'(miss_ready), 64'd0);
    for (int k = 0; k < 4; k++) beat(d, 1'b0, 1'b0, k, 1'b0, '0, 1'b0, 1'b0, 1'b0, "");
    post(d, 1'b0);

    // R10: victim line invalidated at acceptance
    e = mk(60, 5, 0);
    f = mk(61, 5, 0);
    full_fill(e, 1'b0, 1'b0);
    accept(f, 1'b0, 1'b1);
    lookup(e, 1'b0, 1'b0, 1'b0, "R10");
    for (int k = 0; k < 4; k++) beat(f, 1'b0, 1'b1, k, 1'b0, '0, 1'b0, 1'b0, 1'b0, "");
    post(f, 1'b0);
    lookup(e, 1'b0, 1'b0, 1'b0, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule